// File: doc/BRIEF.md
# Sleep and Wake Power Sequencer

This block takes a small microcontroller system into a hardware sleep state and brings it back out. Firmware starts the sequence by writing a one to the sleep bit. The sequencer then raises a bus request to the CPU at once, waits for the CPU's acknowledge, and raises the system-wide power-down line on the next falling edge of the CPU clock. While power-down is high, the flash, the main oscillator, the transient filter and the bandgap stay off.

Wake-up is driven by the always-on low-power clock. Any interrupt whose mask bit is set starts it; the CPU's global interrupt enable plays no part. The interrupt passes through a synchronizer on falling edges of the low-power clock. Power-down is then released on a rising edge. On the following rising edge the voltage-monitor status (power-on reset and low-voltage detect) is captured and a sample strobe is raised. On the falling edge after that, the bus-request release is sent back into the CPU domain. The sleep bit clears itself when the bus request drops.

A sleep write that arrives while a wake-up handshake is still finishing is held. It takes effect on its own once the CPU has dropped its acknowledge and both clock domains are back at rest.

Top module: `pwr_sleep_seq`

## Requirements
- R1: While reset is held and right after it is released, `pd`, `brq`, `sleepBit` and `monStrobe` are 0, and `monHeld` is all zeros.
- R2: A write with `sleepWrEn`=1 and `sleepWrData`=1 in the awake state raises `brq` in the same cycle, with no clock edge in between. `sleepBit` reads 1 from the next rising CPU clock edge.
- R3: A write with `sleepWrData`=0 has no effect: `brq`, `sleepBit` and `pd` stay 0.
- R4: `pd` rises on the first falling CPU clock edge after `bra` goes high, and `brq` stays high for the whole sleep.
- R5: Only an unmasked interrupt wakes the system. A request bit counts only when the `intMask` bit at the same index is 1. A request whose mask bit is 0 leaves `pd` and `brq` high.
- R6: An unmasked interrupt is latched on the third falling low-power clock edge after it rises (two synchronizer stages plus one latch). `pd` falls on the rising low-power edge that follows.
- R7: On the next rising low-power edge, `monStrobe` goes high for exactly one low-power cycle, and `monHeld` captures `monIn` (bit 0 power-on reset, bit 1 low-voltage detect). `monHeld` then keeps that value.
- R8: On the falling low-power edge after the sample, the bus request is released. `brq` and `sleepBit` fall on the third rising CPU edge after it.
- R9: A sleep write made after `brq` has been released and before the wake handshake completes keeps `brq` at 0. `brq` later rises on its own, with `bra` already low, and the system re-enters sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | Fast CPU clock |
| lpClk | input | 1 | Always-on low-power clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| sleepWrEn | input | 1 | Firmware write strobe for the sleep bit |
| sleepWrData | input | 1 | Value written; only 1 has an effect |
| sleepBit | output | 1 | Sleep bit readback |
| brq | output | 1 | Bus request to the CPU |
| bra | input | 1 | Bus acknowledge from the CPU |
| intReq | input | NUM_INT | Raw interrupt request lines |
| intMask | input | NUM_INT | Per-line interrupt enable, 1 = unmasked |
| pd | output | 1 | System-wide power-down |
| monIn | input | MON_W | Voltage-monitor status (bit 0 POR, bit 1 LVD) |
| monStrobe | output | 1 | One low-power-cycle sample strobe for the monitors |
| monHeld | output | MON_W | Monitor status captured at the strobe |

## Verification
The sequence is driven with a plain sleep-and-wake on a high interrupt line, a masked request during sleep, a write of zero, and a sleep write placed inside the closing handshake of a wake-up. The masked request separates the interrupt-and-mask path from a plain OR of the request lines. The zero write shows that only a one starts sleep. Three different monitor values, one per wake, show that each capture happens in its own sample cycle. The late sleep write separates a held request from one that is dropped or one that restarts the sequence before the CPU has released the bus.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  // CPU-clock side of the sequence
  typedef enum logic [2:0] {
    CPU_AWAKE,
    CPU_REQ,
    CPU_ASLEEP,
    CPU_ACKDROP,
    CPU_DONE
  } cpuState_e;

  // low-power-clock side of the wake-up
  typedef enum logic [1:0] {
    LP_IDLE,
    LP_PDOFF,
    LP_SAMPLED
  } lpStage_e;

  // control -> datapath strobes, valid on rising low-power edges
  typedef struct packed {
    logic setPdOff;
    logic clrPdOff;
    logic capMon;
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int STAGES   = 2,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_pos
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       cpuClk,
  input  logic       lpClk,
  input  logic       rstN,
  input  logic       sleepWrEn,
  input  logic       sleepWrData,
  input  logic       bra,
  input  logic       wakeReq,
  output logic       brq,
  output logic       sleepBit,
  output logic       pdArm,
  output seqStrobe_t strobe
);

  cpuState_e state;
  lpStage_e  stage;
  logic brqReg, pendSleep, doneCpu;
  logic relS, intS, asleepS, doneS;
  logic wakeNeg, releaseLp;
  logic wrSet;

  assign wrSet = sleepWrEn & sleepWrData;

  // ---------------- crossings ----------------
  pwrseq_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_intSync (
    .clk(lpClk), .rstN(rstN), .d(wakeReq), .q(intS));
  pwrseq_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_aslSync (
    .clk(lpClk), .rstN(rstN), .d(pdArm), .q(asleepS));
  pwrseq_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_doneSync (
    .clk(lpClk), .rstN(rstN), .d(doneCpu), .q(doneS));
  pwrseq_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_relSync (
    .clk(cpuClk), .rstN(rstN), .d(releaseLp), .q(relS));

  // ---------------- CPU domain ----------------
  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      state     <= CPU_AWAKE;
      brqReg    <= 1'b0;
      sleepBit  <= 1'b0;
      pendSleep <= 1'b0;
      doneCpu   <= 1'b0;
    end else begin
      case (state)
        CPU_AWAKE: begin
          pendSleep <= 1'b0;
          if (wrSet || pendSleep) begin
            state    <= CPU_REQ;
            brqReg   <= 1'b1;
            sleepBit <= 1'b1;
          end
        end
        CPU_REQ: begin
          if (bra) state <= CPU_ASLEEP;
        end
        CPU_ASLEEP: begin
          if (relS) begin
            state    <= CPU_ACKDROP;
            brqReg   <= 1'b0;
            sleepBit <= 1'b0;
          end
        end
        CPU_ACKDROP: begin
          if (wrSet) pendSleep <= 1'b1;
          if (!bra) begin
            state   <= CPU_DONE;
            doneCpu <= 1'b1;
          end
        end
        CPU_DONE: begin
          if (wrSet) pendSleep <= 1'b1;
          if (!relS) begin
            state   <= CPU_AWAKE;
            doneCpu <= 1'b0;
          end
        end
        default: state <= CPU_AWAKE;
      endcase
    end
  end

  // request goes out combinationally on the write itself
  assign brq = brqReg | ((state == CPU_AWAKE) & (wrSet | pendSleep));

  // power-down armed on the falling edge after the acknowledge
  always_ff @(negedge cpuClk or negedge rstN) begin
    if (!rstN)                              pdArm <= 1'b0;
    else if (state == CPU_REQ && bra)       pdArm <= 1'b1;
    else if (state == CPU_ACKDROP)          pdArm <= 1'b0;
  end

  // ---------------- low-power domain, falling edges ----------------
  always_ff @(negedge lpClk or negedge rstN) begin
    if (!rstN) begin
      wakeNeg   <= 1'b0;
      releaseLp <= 1'b0;
    end else if (doneS) begin
      wakeNeg   <= 1'b0;
      releaseLp <= 1'b0;
    end else begin
      if (!wakeNeg && asleepS && intS) wakeNeg <= 1'b1;
      if (stage == LP_SAMPLED)         releaseLp <= 1'b1;
    end
  end

  // ---------------- low-power domain, rising edges ----------------
  always_comb begin
    strobe.setPdOff = (stage == LP_IDLE) && wakeNeg && !doneS;
    strobe.capMon   = (stage == LP_PDOFF) && !doneS;
    strobe.clrPdOff = doneS;
  end

  always_ff @(posedge lpClk or negedge rstN) begin
    if (!rstN)                stage <= LP_IDLE;
    else if (doneS)           stage <= LP_IDLE;
    else if (strobe.setPdOff) stage <= LP_PDOFF;
    else if (strobe.capMon)   stage <= LP_SAMPLED;
  end

  // ---------------- assertions ----------------
  assert_pd_after_ack_R4: assert property (@(negedge cpuClk) disable iff (!rstN)
    $rose(pdArm) |-> bra);

  assert_pdarm_not_awake_R4: assert property (@(posedge cpuClk) disable iff (!rstN)
    pdArm |-> (state != CPU_AWAKE));

  assert_brq_drop_on_release_R8: assert property (@(posedge cpuClk) disable iff (!rstN)
    $fell(brq) |-> relS);

  assert_no_brq_during_wake_R9: assert property (@(posedge cpuClk) disable iff (!rstN)
    (state == CPU_ACKDROP || state == CPU_DONE) |-> !brq);

  assert_wake_needs_int_R6: assert property (@(negedge lpClk) disable iff (!rstN)
    $rose(wakeNeg) |-> $past(intS));

  assert_release_after_sample_R8: assert property (@(negedge lpClk) disable iff (!rstN)
    $rose(releaseLp) |-> (stage == LP_SAMPLED));

endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int NUM_INT = 8,
  parameter int MON_W   = 2
) (
  input  logic               lpClk,
  input  logic               rstN,
  input  logic [NUM_INT-1:0] intReq,
  input  logic [NUM_INT-1:0] intMask,
  input  logic [MON_W-1:0]   monIn,
  input  logic               pdArm,
  input  seqStrobe_t         strobe,
  output logic               wakeReq,
  output logic               pd,
  output logic               monStrobe,
  output logic [MON_W-1:0]   monHeld
);

  logic pdOffLp;

  assign wakeReq = |(intReq & intMask);

  always_ff @(posedge lpClk or negedge rstN) begin
    if (!rstN) begin
      pdOffLp   <= 1'b0;
      monStrobe <= 1'b0;
      monHeld   <= '0;
    end else begin
      if (strobe.clrPdOff)      pdOffLp <= 1'b0;
      else if (strobe.setPdOff) pdOffLp <= 1'b1;
      monStrobe <= strobe.capMon;
      if (strobe.capMon) monHeld <= monIn;
    end
  end

  assign pd = pdArm & ~pdOffLp;

  assert_strobe_single_R7: assert property (@(posedge lpClk) disable iff (!rstN)
    monStrobe |=> !monStrobe);

  assert_pd_low_at_sample_R7: assert property (@(posedge lpClk) disable iff (!rstN)
    monStrobe |-> !pd);

endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
  import pwrseq_pkg::*;
#(
  parameter int NUM_INT     = 8,
  parameter int MON_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               cpuClk,
  input  logic               lpClk,
  input  logic               rstN,
  input  logic               sleepWrEn,
  input  logic               sleepWrData,
  output logic               sleepBit,
  output logic               brq,
  input  logic               bra,
  input  logic [NUM_INT-1:0] intReq,
  input  logic [NUM_INT-1:0] intMask,
  output logic               pd,
  input  logic [MON_W-1:0]   monIn,
  output logic               monStrobe,
  output logic [MON_W-1:0]   monHeld
);

  seqStrobe_t strobe;
  logic       pdArm;
  logic       wakeReq;

  pwrseq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .cpuClk(cpuClk), .lpClk(lpClk), .rstN(rstN),
    .sleepWrEn(sleepWrEn), .sleepWrData(sleepWrData),
    .bra(bra), .wakeReq(wakeReq),
    .brq(brq), .sleepBit(sleepBit), .pdArm(pdArm), .strobe(strobe));

  pwrseq_dp #(.NUM_INT(NUM_INT), .MON_W(MON_W)) u_dp (
    .lpClk(lpClk), .rstN(rstN),
    .intReq(intReq), .intMask(intMask), .monIn(monIn),
    .pdArm(pdArm), .strobe(strobe),
    .wakeReq(wakeReq), .pd(pd), .monStrobe(monStrobe), .monHeld(monHeld));

endmodule

// File: tb/pwr_sleep_seq_tb_top.sv
module pwr_sleep_seq_tb_top;

  localparam int NI = 8;
  localparam int MW = 2;

  logic cpuClk = 1'b0, lpClk = 1'b0, rstN = 1'b0;
  logic sleepWrEn = 1'b0, sleepWrData = 1'b0;
  logic bra, cpuSeen;
  logic [NI-1:0] intReq = '0, intMask = 8'hF0;
  logic [MW-1:0] monIn = '0;
  logic sleepBit, brq, pd, monStrobe;
  logic [MW-1:0] monHeld;

  int nCmp = 0, nBad = 0;
  bit track = 1'b0;
  bit finished = 1'b0;
  // behavioural reference state
  logic mPd = 0, mBrq = 0, mSleep = 0, mStrobe = 0;
  logic [MW-1:0] mHeld = '0;

  pwr_sleep_seq #(.NUM_INT(NI), .MON_W(MW)) dut_i (
    .cpuClk(cpuClk), .lpClk(lpClk), .rstN(rstN),
    .sleepWrEn(sleepWrEn), .sleepWrData(sleepWrData), .sleepBit(sleepBit),
    .brq(brq), .bra(bra), .intReq(intReq), .intMask(intMask), .pd(pd),
    .monIn(monIn), .monStrobe(monStrobe), .monHeld(monHeld));

  always #10 cpuClk = ~cpuClk;                 // 50 MHz
  initial begin #5; forever #80 lpClk = ~lpClk; end

  // CPU handshake model: sample request, acknowledge one edge later, drop at once
  always @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin cpuSeen <= 1'b0; bra <= 1'b0; end
    else begin cpuSeen <= brq; bra <= brq ? cpuSeen : 1'b0; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(posedge cpuClk) begin
    #3;
    if (track && rstN && !finished) begin
      chk("R4 pd", pd, mPd);
      chk("R2 brq", brq, mBrq);
      chk("R8 sleepBit", sleepBit, mSleep);
      chk("R7 monStrobe", monStrobe, mStrobe);
      chk("R7 monHeld", monHeld, mHeld);
    end
  end

  task automatic writeSleep(input logic val);
    @(posedge cpuClk); #2;
    sleepWrEn = 1'b1; sleepWrData = val;
    if (val) mBrq = 1'b1;
    #1 chk(val ? "R2 brq immediate" : "R3 brq on zero write", brq, val);
    @(posedge cpuClk); #1;
    if (val) mSleep = 1'b1;
    #1 sleepWrEn = 1'b0; sleepWrData = 1'b0;
    if (val) begin
      @(posedge cpuClk);
      @(negedge cpuClk); #1 mPd = 1'b1;
      chk("R4 pd after ack", pd, 1);
    end else begin
      repeat (3) @(posedge cpuClk);
      #3;
      chk("R3 sleepBit", sleepBit, 0);
      chk("R3 brq", brq, 0);
      chk("R3 pd", pd, 0);
    end
  endtask

  task automatic wake(input int bitIdx, input logic [MW-1:0] mon, input bit pendWrite);
    @(posedge cpuClk); #2;
    monIn = mon;
    intReq[bitIdx] = 1'b1;
    repeat (3) @(negedge lpClk);
    #1 chk("R6 pd before rise", pd, 1);
    @(posedge lpClk); #1 mPd = 1'b0;
    chk("R6 pd released", pd, 0);
    @(posedge lpClk); #1 mStrobe = 1'b1; mHeld = mon;
    @(negedge lpClk);
    fork
      begin @(posedge lpClk); #1 mStrobe = 1'b0; end
      begin repeat (3) @(posedge cpuClk); #1 mBrq = 1'b0; mSleep = 1'b0; end
    join
    if (pendWrite) begin
      track = 1'b0;
      @(posedge cpuClk); #2;
      sleepWrEn = 1'b1; sleepWrData = 1'b1;
      #1 chk("R9 brq held during wake", brq, 0);
      @(posedge cpuClk); #2;
      sleepWrEn = 1'b0; sleepWrData = 1'b0;
      intReq = '0;
      #1 chk("R9 brq still low", brq, 0);
      begin
        bit seen = 1'b0;
        for (int i = 0; i < 400 && !seen; i++) begin
          @(posedge cpuClk); #3;
          if (brq) seen = 1'b1;
        end
        chk("R9 held request fires", seen, 1);
        chk("R9 ack dropped first", bra, 0);
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
          @(posedge cpuClk); #4;
          if (pd) seen = 1'b1;
        end
        chk("R9 re-enters sleep", seen, 1);
      end
      mBrq = 1'b1; mSleep = 1'b1; mPd = 1'b1;
      track = 1'b1;
    end else begin
      @(posedge cpuClk); #2 intReq = '0;
      repeat (8) @(posedge lpClk);
    end
  endtask

  initial begin
    #15;
    chk("R1 pd in reset", pd, 0);
    chk("R1 brq in reset", brq, 0);
    chk("R1 sleepBit in reset", sleepBit, 0);
    chk("R1 monStrobe in reset", monStrobe, 0);
    #30 rstN = 1'b1;
    @(posedge cpuClk); #3;
    chk("R1 brq after reset", brq, 0);
    chk("R1 monHeld after reset", monHeld, 0);
    track = 1'b1;

    writeSleep(1'b0);

    writeSleep(1'b1);
    repeat (4) @(posedge lpClk);
    // masked line: mask bit 2 is 0
    @(posedge cpuClk); #2 intReq[2] = 1'b1;
    repeat (6) @(posedge lpClk);
    #3;
    chk("R5 masked keeps pd", pd, 1);
    chk("R5 masked keeps brq", brq, 1);
    @(posedge cpuClk); #2 intReq = '0;
    repeat (2) @(posedge lpClk);

    wake(5, 2'b01, 1'b0);

    writeSleep(1'b1);
    repeat (4) @(posedge lpClk);
    wake(7, 2'b10, 1'b1);

    repeat (4) @(posedge lpClk);
    @(posedge cpuClk); #2 intMask = 8'h01;
    wake(0, 2'b11, 1'b0);
    chk("R7 monHeld kept", monHeld, 2'b11);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      nCmp++; nBad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule